// File: doc/BRIEF.md
# Status Byte with Service Request

The block sits at the very top of a status reporting hierarchy. Each lower register group reports a single summary line. Those lines form an 8-bit status byte. Position 6 of that byte is not taken from an input. It is computed as a master summary: it is set when any other status bit is set and its service request enable bit is also set.

An 8-bit service request enable register selects which status bits may raise a request. Enable bit 6 has no effect. When an enabled status bit goes from 0 to 1, the block raises its request output. The output then stays high until a serial-poll read acknowledges it.

A small register port gives access to the block. Address 0 reads the status byte, and address 1 reads or writes the enable register. A separate poll strobe stands for the serial-poll read.

Top module: `status_byte_srq`

## Requirements
- R1: With `reg_addr` = 0, `reg_rdata` bits 0 to 5 and bit 7 show `sum_in` of the same cycle, combinationally; `sum_in[6]` has no effect on any output.
- R2: With `reg_addr` = 0, `reg_rdata[6]` is 1 exactly when some bit i other than 6 has both `sum_in[i]` and enable bit i equal to 1.
- R3: A clock edge with `reg_wr` = 1 and `reg_addr` = 1 loads `reg_wdata` into the enable register. With `reg_addr` = 1, `reg_rdata` returns the enable register. A write with `reg_addr` = 0 changes nothing.
- R4: Enable bit 6 always reads 0, and it never takes part in the summary or in a request.
- R5: `srq` goes high one clock after an edge where an enabled bit (not bit 6) of `sum_in` is 1 and was 0 at the previous edge. A bit that stays high does not raise `srq`, and neither does enabling a bit that is already high.
- R6: Once high, `srq` stays high until a clock edge with `poll_rd` = 1. Reading the status byte through the register port does not clear it.
- R7: If a new enabled rise happens at the same edge as `poll_rd`, `srq` stays high.
- R8: Reset (`rst_n` = 0) clears the enable register, `srq` and the stored previous status. A status bit that is already high when reset is released therefore raises no request until it is enabled and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sum_in | input | 8 | Summary lines from the lower register groups (bit 6 unused) |
| reg_addr | input | 1 | 0 selects the status byte, 1 selects the enable register |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| poll_rd | input | 1 | Serial-poll read strobe; acknowledges the request |
| srq | output | 1 | Service request flag |

## Verification
The request logic is first exercised in several ways that must not raise a request: a bit held high through reset, a bit enabled while already high, and activity on bit 6 only. It is then driven with a genuine enabled 0-to-1 edge. Each of the non-triggering cases separates edge detection from level detection or from enable masking. The flag is read with status queries, which must leave it set, and with poll strobes, which must clear it. One poll is placed on the same edge as a new rise, to show which of the two wins. A long run of random summary patterns, enable writes and polls is then compared every cycle against a behavioural model of the summary bit and the flag.

// File: rtl/status_byte_srq.sv
module status_byte_srq #(
  parameter int W = 8,
  parameter int SUM_BIT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sum_in,
  input  logic         reg_addr,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         poll_rd,
  output logic         srq
);
  localparam logic [W-1:0] KEEP = ~(W'(1) << SUM_BIT);

  logic [W-1:0] en, prev, stb, rise;

  assign rise = sum_in & ~prev & en & KEEP;

  always_comb begin
    stb = sum_in;
    stb[SUM_BIT] = |(sum_in & en & KEEP);
  end

  assign reg_rdata = reg_addr ? en : stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      prev <= '0;
      srq  <= 1'b0;
    end else begin
      prev <= sum_in & KEEP;
      if (reg_wr && reg_addr) en <= reg_wdata & KEEP;
      if (|rise) srq <= 1'b1;
      else if (poll_rd) srq <= 1'b0;
    end
  end
endmodule

module status_byte_srq_chk #(
  parameter int W = 8,
  parameter int SUM_BIT = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] sum_in,
  input logic         reg_addr,
  input logic         reg_wr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] reg_rdata,
  input logic         poll_rd,
  input logic         srq,
  input logic [W-1:0] en,
  input logic [W-1:0] prev
);
  localparam logic [W-1:0] KEEP = ~(W'(1) << SUM_BIT);
  logic trig;
  assign trig = |(sum_in & ~prev & en & KEEP);

  p_summary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> reg_rdata[SUM_BIT] == |(sum_in & en & KEEP));
  p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr) |=> en == ($past(reg_wdata) & KEEP));
  p_enable_bit6_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr |-> !reg_rdata[SUM_BIT]);
  p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> srq);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!srq && !trig) |=> !srq);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (srq && !poll_rd) |=> srq);
  p_poll_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !trig) |=> !srq);
endmodule

bind status_byte_srq status_byte_srq_chk #(.W(W), .SUM_BIT(SUM_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .poll_rd(poll_rd), .srq(srq), .en(en), .prev(prev)
);

// File: tb/status_byte_srq_test.sv
module status_byte_srq_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] sum_in = 8'hFF;
  logic       reg_addr = 0, reg_wr = 0, poll_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       srq;
  int compared = 0, mismatched = 0;

  logic [7:0] m_en = 0, m_prev = 0;
  logic       m_srq = 0;

  always #5 clk = ~clk;

  status_byte_srq uut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_stb();
    logic [7:0] s = sum_in;
    s[6] = |(sum_in & m_en & 8'hBF);
    return s;
  endfunction

  task automatic step(logic [7:0] s, logic a, logic w, logic [7:0] d, logic p);
    logic [7:0] r;
    sum_in = s; reg_addr = a; reg_wr = w; reg_wdata = d; poll_rd = p;
    #1;
    if (a) check("R3/R4 enable readback", reg_rdata, m_en);
    else   check("R1/R2 status byte", reg_rdata, model_stb());
    check("R5/R6/R7 srq", {7'b0, srq}, {7'b0, m_srq});
    @(posedge clk);
    r = s & ~m_prev & m_en & 8'hBF;
    m_srq = (|r) | (m_srq & ~p);
    m_prev = s & 8'hBF;
    if (w && a) m_en = d & 8'hBF;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    reg_addr = 1; #1;
    check("R8 enable reset", reg_rdata, 8'h00);
    check("R8 srq reset", {7'b0, srq}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    step(8'hFF, 0, 0, 0, 0);
    step(8'h01, 1, 1, 8'h01, 0);
    step(8'h01, 0, 0, 0, 0);
    check("R5 enabling a high bit leaves srq low", {7'b0, srq}, 8'h00);
    step(8'h00, 0, 0, 0, 0);
    step(8'h01, 0, 0, 0, 0);
    step(8'h01, 0, 0, 0, 0);
    check("R5 rise sets srq", {7'b0, srq}, 8'h01);
    step(8'h01, 0, 0, 0, 0);
    step(8'h01, 0, 1, 8'h00, 0);
    step(8'h00, 0, 0, 0, 1);
    check("R6 poll clears srq", {7'b0, srq}, 8'h00);
    step(8'h00, 1, 1, 8'hFF, 0);
    step(8'h00, 1, 0, 0, 0);
    step(8'h40, 0, 0, 0, 0);
    step(8'h00, 0, 0, 0, 0);
    step(8'h40, 0, 0, 0, 0);
    check("R4 bit 6 activity raises no srq", {7'b0, srq}, 8'h00);
    step(8'h80, 0, 0, 0, 0);
    step(8'h80, 0, 0, 0, 0);
    step(8'h00, 0, 0, 0, 1);
    step(8'h02, 0, 0, 0, 1);
    step(8'h02, 0, 0, 0, 0);
    check("R7 rise beats poll", {7'b0, srq}, 8'h01);
    for (int i = 0; i < 3000; i++)
      step(8'($urandom), 1'($urandom), ($urandom % 5) == 0, 8'($urandom),
           ($urandom % 4) == 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule